// File: doc/BRIEF.md
# UART Interrupt Source Prioritizer

This block decides which of three UART interrupt causes is reported to software and drives the interrupt request line toward an external interrupt controller. It looks at the enable bits programmed by software and at three status conditions: receive overrun, receive data ready and transmitter empty. Every cycle it forms a 4-bit identification code naming the most urgent enabled cause. The code and the request line are both registered.

Overrun and data-ready are level sources: their interrupt lasts as long as the status bit and its enable are both high. Transmitter-empty is edge-armed. A pending flag sets when the empty condition appears, or when its enable is switched on while the transmitter is already empty. The flag clears when software reads the identification code while it reports transmitter-empty, or when software writes a new character to transmit. Once cleared, a transmitter that stays empty does not raise the interrupt again.

Top module: `uart_iid`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `iid_code` is 4'b0001 and `irq` is 0.
- R2: When `ie_line` and `st_overrun` are both 1 at a clock edge, `iid_code` is 4'b0110 after that edge, whatever the other sources are doing.
- R3: When the overrun source is inactive and `ie_rx` and `st_rx_ready` are both 1 at an edge, `iid_code` is 4'b0100 after that edge.
- R4: When neither higher source is active and `ie_tx` is 1 with the transmit-empty flag pending, `iid_code` is 4'b0010.
- R5: With no enabled source active, `iid_code` is 4'b0001. `irq` is 1 exactly when `iid_code` differs from 4'b0001.
- R6: An `iid_rd` pulse in a cycle where `iid_code` reads 4'b0010 clears the pending flag at that edge, so the code drops one cycle later. An `iid_rd` pulse while any other code is shown leaves the flag untouched.
- R7: A `thr_wr` pulse clears the pending transmit-empty flag at that edge.
- R8: The flag sets on a 0-to-1 change of `st_tx_empty`. It also sets on a 0-to-1 change of `ie_tx` while `st_tx_empty` is 1. Holding `st_tx_empty` at 1 after a clear does not set it again.
- R9: The sources are level-sensitive and sampled every cycle. Removing an overrun or data-ready condition changes `iid_code` on the next edge.
- R10: The pending flag is forced to 0 whenever `st_tx_empty` is 0. A clear pulse wins over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ie_line | input | 1 | Enable for the overrun (line status) interrupt |
| ie_rx | input | 1 | Enable for the receive-data interrupt |
| ie_tx | input | 1 | Enable for the transmitter-empty interrupt |
| st_overrun | input | 1 | Receive overrun status |
| st_rx_ready | input | 1 | Receive data ready status |
| st_tx_empty | input | 1 | Transmit holding register empty status |
| iid_rd | input | 1 | One-cycle pulse per read of the identification code |
| thr_wr | input | 1 | One-cycle pulse per write of the transmit holding register |
| iid_code | output | 4 | Registered identification code |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The bench goes after these orderings:
- All three sources active at once. A wrong priority shows 0100 or 0010 instead of 0110.
- An identification read while the receive code is displayed. A design that clears the flag on any read loses the later transmitter-empty interrupt.
- Holding the transmitter empty after a clear. A level-sensitive design re-raises 0010 at once.
- Re-enabling the transmit interrupt while the transmitter is empty. A design that only watches the status edge never re-arms.
- A write pulse landing on the same edge as the empty rising edge. A design where set wins leaves a stale pending interrupt.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;
  localparam int CODE_W  = 4;
  localparam int NUM_SRC = 3;

  // source index order is the priority order: index 0 wins
  localparam int SRC_LINE = 0;
  localparam int SRC_RXD  = 1;
  localparam int SRC_TXE  = 2;

  localparam logic [CODE_W-1:0] ID_NONE = 4'b0001;
  localparam logic [CODE_W-1:0] ID_LINE = 4'b0110;
  localparam logic [CODE_W-1:0] ID_RXD  = 4'b0100;
  localparam logic [CODE_W-1:0] ID_TXE  = 4'b0010;

  function automatic logic [CODE_W-1:0] src_code(input int idx);
    case (idx)
      SRC_LINE: src_code = ID_LINE;
      SRC_RXD:  src_code = ID_RXD;
      SRC_TXE:  src_code = ID_TXE;
      default:  src_code = ID_NONE;
    endcase
  endfunction
endpackage

// File: rtl/uart_iid_txpend.sv
module uart_iid_txpend
  import uart_iid_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ie_tx,
  input  logic              st_tx_empty,
  input  logic              iid_rd,
  input  logic              thr_wr,
  input  logic [CODE_W-1:0] cur_code,
  output logic              pend
);
  logic empty_q;
  logic ie_q;
  logic arm;
  logic clr;

  assign arm = (st_tx_empty & ~empty_q) | (ie_tx & ~ie_q & st_tx_empty);
  assign clr = thr_wr | (iid_rd & (cur_code == ID_TXE));

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b0;
      ie_q    <= 1'b0;
      pend    <= 1'b0;
    end else begin
      empty_q <= st_tx_empty;
      ie_q    <= ie_tx;
      pend    <= st_tx_empty & ~clr & (pend | arm);
    end
  end

  // R7: a transmit write always leaves the flag clear
  a_r7_write_clears: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> !pend);
  // R6: reading the transmitter-empty code clears the flag
  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (iid_rd && cur_code == ID_TXE) |=> !pend);
  // R10: no pending flag without an empty transmitter
  a_r10_needs_empty: assert property (@(posedge clk) disable iff (rst)
    !st_tx_empty |=> !pend);
endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_iid.sv
module uart_iid
  import uart_iid_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ie_line,
  input  logic              ie_rx,
  input  logic              ie_tx,
  input  logic              st_overrun,
  input  logic              st_rx_ready,
  input  logic              st_tx_empty,
  input  logic              iid_rd,
  input  logic              thr_wr,
  output logic [CODE_W-1:0] iid_code,
  output logic              irq
);
  logic               tx_pend;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] grant;
  logic [CODE_W-1:0]  code_next;

  uart_iid_txpend u_txpend (
    .clk        (clk),
    .rst        (rst),
    .ie_tx      (ie_tx),
    .st_tx_empty(st_tx_empty),
    .iid_rd     (iid_rd),
    .thr_wr     (thr_wr),
    .cur_code   (iid_code),
    .pend       (tx_pend)
  );

  always_comb begin
    req           = '0;
    req[SRC_LINE] = ie_line & st_overrun;
    req[SRC_RXD]  = ie_rx & st_rx_ready;
    req[SRC_TXE]  = ie_tx & tx_pend;
  end

  uart_iid_prio #(.N(NUM_SRC)) u_prio (
    .req  (req),
    .grant(grant)
  );

  always_comb begin
    code_next = ID_NONE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) code_next = src_code(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iid_code <= ID_NONE;
      irq      <= 1'b0;
    end else begin
      iid_code <= code_next;
      irq      <= (code_next != ID_NONE);
    end
  end

  // R5: request line tracks the code
  a_r5_irq_matches_code: assert property (@(posedge clk) disable iff (rst)
    irq == (iid_code != ID_NONE));
  // R2: overrun wins over everything
  a_r2_overrun_wins: assert property (@(posedge clk) disable iff (rst)
    (ie_line && st_overrun) |=> iid_code == ID_LINE);
  // R3: receive data beats transmitter-empty
  a_r3_rx_second: assert property (@(posedge clk) disable iff (rst)
    (!(ie_line && st_overrun) && ie_rx && st_rx_ready) |=> iid_code == ID_RXD);
  // R5: nothing enabled means no interrupt
  a_r5_idle_none: assert property (@(posedge clk) disable iff (rst)
    (!ie_line && !ie_rx && !ie_tx) |=> (iid_code == ID_NONE && !irq));
endmodule

// File: tb/tb_uart_iid.sv
module tb_uart_iid;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ie_line = 0, ie_rx = 0, ie_tx = 0;
  logic st_overrun = 0, st_rx_ready = 0, st_tx_empty = 0;
  logic iid_rd = 0, thr_wr = 0;
  logic [3:0] iid_code;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  uart_iid dut (
    .clk(clk), .rst(rst), .ie_line(ie_line), .ie_rx(ie_rx), .ie_tx(ie_tx),
    .st_overrun(st_overrun), .st_rx_ready(st_rx_ready), .st_tx_empty(st_tx_empty),
    .iid_rd(iid_rd), .thr_wr(thr_wr), .iid_code(iid_code), .irq(irq)
  );

  // reference model built from the requirements
  logic m_eq, m_iq, m_pend, m_irq;
  logic [3:0] m_code;

  function automatic logic [3:0] pick(input logic lo, input logic rx, input logic tx);
    if (lo) return 4'b0110;
    if (rx) return 4'b0100;
    if (tx) return 4'b0010;
    return 4'b0001;
  endfunction

  always @(posedge clk) begin
    logic clr, arm, np;
    logic [3:0] nc;
    cyc = cyc + 1;
    if (rst) begin
      m_eq = 0; m_iq = 0; m_pend = 0; m_code = 4'b0001; m_irq = 0;
    end else begin
      clr = thr_wr | (iid_rd & (m_code == 4'b0010));
      arm = (st_tx_empty & ~m_eq) | (ie_tx & ~m_iq & st_tx_empty);
      np  = st_tx_empty & ~clr & (m_pend | arm);
      nc  = pick(ie_line & st_overrun, ie_rx & st_rx_ready, ie_tx & m_pend);
      m_code = nc;
      m_irq  = (nc != 4'b0001);
      m_pend = np;
      m_eq   = st_tx_empty;
      m_iq   = ie_tx;
    end
  end

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check("R9 model code", iid_code, m_code);
    check("R5 model irq", {3'b0, irq}, {3'b0, m_irq});
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check("R1 reset code", iid_code, 4'b0001);
    check("R1 reset irq", {3'b0, irq}, 4'b0000);
    rst = 0;
    step();
    check("R1 after reset", iid_code, 4'b0001);

    // all sources active
    ie_line = 1; ie_rx = 1; ie_tx = 1;
    st_overrun = 1; st_rx_ready = 1; st_tx_empty = 1;
    steps(2);
    check("R2 overrun first", iid_code, 4'b0110);
    check("R5 irq high", {3'b0, irq}, 4'b0001);
    st_overrun = 0; step();
    check("R3 rx second, R9 next cycle", iid_code, 4'b0100);
    st_rx_ready = 0; step();
    check("R4 tx lowest", iid_code, 4'b0010);

    // read clears
    iid_rd = 1; step(); iid_rd = 0;
    step();
    check("R6 read clears", iid_code, 4'b0001);
    check("R5 irq low", {3'b0, irq}, 4'b0000);
    steps(3);
    check("R8 no re-raise while empty held", iid_code, 4'b0001);

    // re-arm by enable edge
    ie_tx = 0; step(); ie_tx = 1; steps(2);
    check("R8 enable edge arms", iid_code, 4'b0010);
    thr_wr = 1; step(); thr_wr = 0; step();
    check("R7 write clears", iid_code, 4'b0001);

    // empty rising edge then drop
    st_tx_empty = 0; step(); st_tx_empty = 1; steps(2);
    check("R8 empty edge arms", iid_code, 4'b0010);
    st_tx_empty = 0; steps(2);
    check("R10 flag drops with empty low", iid_code, 4'b0001);

    // read while receive code shown leaves flag alone
    st_tx_empty = 1; st_rx_ready = 1; steps(2);
    check("R3 rx over pending tx", iid_code, 4'b0100);
    iid_rd = 1; step(); iid_rd = 0;
    st_rx_ready = 0; step();
    check("R6 read of other code keeps flag", iid_code, 4'b0010);

    // clear beats set
    thr_wr = 1; step(); thr_wr = 0;
    st_tx_empty = 0; step();
    st_tx_empty = 1; thr_wr = 1; step(); thr_wr = 0;
    steps(2);
    check("R10 clear wins over set", iid_code, 4'b0001);

    // nothing enabled
    ie_line = 0; ie_rx = 0; ie_tx = 0; st_overrun = 1; st_rx_ready = 1;
    steps(2);
    check("R5 none enabled", iid_code, 4'b0001);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      ie_line     = ($urandom % 4) != 0;
      ie_rx       = ($urandom % 4) != 0;
      ie_tx       = ($urandom % 5) != 0;
      st_overrun  = ($urandom % 6) == 0;
      st_rx_ready = ($urandom % 3) == 0;
      st_tx_empty = ($urandom % 3) != 0;
      iid_rd      = ($urandom % 4) == 0;
      thr_wr      = ($urandom % 8) == 0;
      step();
    end
    iid_rd = 0; thr_wr = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule